// File: doc/BRIEF.md
# Fair Alternating Four-Input FIFO Merge

This block merges four first-word-fall-through FIFOs into a single output stream. Each source FIFO shows an empty flag and its head word. The block answers with a one-cycle read strobe when it takes that word. The block is a two-level tree of three identical two-input nodes. Two leaf nodes each serve a pair of FIFOs, and a root node serves the two leaf nodes. Every node holds one word in an output register. Towards its parent it looks like a FIFO: the register being empty is the empty flag, and a pop is a read strobe.

Each node arbitrates so that neither side can starve the other. After a word is taken from one side, a waiting word on the other side wins the next slot. When both sides hold data the node therefore alternates between them. A side is read on back-to-back cycles only while the other side has nothing to offer. From the idle state, with both sides ready at once, the lower-numbered side goes first. The output uses a valid/ready handshake. Backpressure stalls the tree without dropping, duplicating or reordering any word that came from the same input.

Top module: `fm_merge4`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, and no `in_rd` bit is raised while all inputs are empty.
- R2: `in_rd[i]` is raised only in a cycle where `in_empty[i]` is 0.
- R3: In any cycle, at most one of `in_rd[0]`/`in_rd[1]` is high, and at most one of `in_rd[2]`/`in_rd[3]` is high.
- R4: If an input of a pair is read, and the other input of that pair is non-empty in that cycle, then the first input is not read in the next cycle.
- R5: When both inputs of a node have data, they are served alternately. From idle with both ready, the lower-numbered side (side A) is served first.
- R6: An input whose partner is empty is read on consecutive cycles. With `out_ready` held at 1, one word leaves per cycle.
- R7: With all four FIFOs loaded and no stalls, the output order is input 0, 2, 1, 3, repeated. Input words use the data value `{input index[3:0], word index[3:0]}`.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R9: Words from one input leave in the order they were in that FIFO. No word is lost or repeated, whatever the `out_ready` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_empty | input | 4 | Empty flag of each source FIFO |
| in_data | input | 4*DATA_W | Head words of the source FIFOs, input i at bits [i*DATA_W +: DATA_W] |
| in_rd | output | 4 | Read strobe to each source FIFO |
| out_valid | output | 1 | Output register holds a word |
| out_data | output | DATA_W | Output word |
| out_ready | input | 1 | Consumer takes the word when high with `out_valid` |

## Verification
Two functions can fall in the same cycle at a node: the parent popping the node's held word, and the node loading a new word from one of its two sides. A loaded word must appear at once in the same cycle as the pop. The fairness choice must also be made against the side that was just served. The bench provokes this by preloading all four FIFOs and running with `out_ready` either held high or toggling every cycle. Both runs must give the same interleaved order. The bench judges the result by comparing the captured output sequence, word for word, with the sequence written in the requirements.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } sel_state_t;
endpackage

// File: rtl/fm_arb.sv
module fm_arb
  import fm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_avail,
  input  logic b_avail,
  input  logic take,
  output logic gnt_a,
  output logic gnt_b
);
  sel_state_t state;
  logic pick_a, pick_b;

  // the side not served last wins when both offer data
  always_comb begin
    unique case (state)
      SEL_A: begin
        pick_b = b_avail;
        pick_a = a_avail & ~b_avail;
      end
      SEL_B: begin
        pick_a = a_avail;
        pick_b = b_avail & ~a_avail;
      end
      default: begin
        pick_a = a_avail;
        pick_b = b_avail & ~a_avail;
      end
    endcase
  end

  assign gnt_a = take & pick_a;
  assign gnt_b = take & pick_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEL_IDLE;
    end else if (take) begin
      if (pick_a)      state <= SEL_A;
      else if (pick_b) state <= SEL_B;
      else             state <= SEL_IDLE;
    end
  end
endmodule

// File: rtl/fm_stage.sv
module fm_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pop,
  output logic              free,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  assign free = ~valid | pop;

  always_ff @(posedge clk) begin
    if (rst)       valid <= 1'b0;
    else if (load) valid <= 1'b1;
    else if (pop)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end
endmodule

// File: rtl/fm_node.sv
module fm_node #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_empty,
  input  logic [DATA_W-1:0] a_data,
  output logic              a_rd,
  input  logic              b_empty,
  input  logic [DATA_W-1:0] b_data,
  output logic              b_rd,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_data,
  input  logic              o_pop
);
  logic free;

  fm_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .a_avail (~a_empty),
    .b_avail (~b_empty),
    .take    (free),
    .gnt_a   (a_rd),
    .gnt_b   (b_rd)
  );

  fm_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .load      (a_rd | b_rd),
    .load_data (a_rd ? a_data : b_data),
    .pop       (o_pop),
    .free      (free),
    .valid     (o_valid),
    .data      (o_data)
  );
endmodule

// File: rtl/fm_merge4.sv
module fm_merge4 #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          in_empty,
  input  logic [4*DATA_W-1:0] in_data,
  output logic [3:0]          in_rd,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  input  logic                out_ready
);
  localparam int NUM_IN = 4;
  localparam int PAIRS  = NUM_IN / 2;

  logic [PAIRS-1:0]        leaf_valid;
  logic [PAIRS-1:0]        leaf_pop;
  logic [DATA_W-1:0]       leaf_data [PAIRS];

  for (genvar p = 0; p < PAIRS; p++) begin : g_leaf
    fm_node #(.DATA_W(DATA_W)) u_leaf (
      .clk     (clk),
      .rst     (rst),
      .a_empty (in_empty[2*p]),
      .a_data  (in_data[(2*p)*DATA_W +: DATA_W]),
      .a_rd    (in_rd[2*p]),
      .b_empty (in_empty[2*p+1]),
      .b_data  (in_data[(2*p+1)*DATA_W +: DATA_W]),
      .b_rd    (in_rd[2*p+1]),
      .o_valid (leaf_valid[p]),
      .o_data  (leaf_data[p]),
      .o_pop   (leaf_pop[p])
    );
  end

  fm_node #(.DATA_W(DATA_W)) u_root (
    .clk     (clk),
    .rst     (rst),
    .a_empty (~leaf_valid[0]),
    .a_data  (leaf_data[0]),
    .a_rd    (leaf_pop[0]),
    .b_empty (~leaf_valid[1]),
    .b_data  (leaf_data[1]),
    .b_rd    (leaf_pop[1]),
    .o_valid (out_valid),
    .o_data  (out_data),
    .o_pop   (out_ready)
  );
endmodule

// File: rtl/fm_merge4_chk.sv
module fm_merge4_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        in_empty,
  input logic [3:0]        in_rd,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (in_rd & in_empty) == 4'b0000);

  // R3
  one_rd_per_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_rd[1:0]) && $onehot0(in_rd[3:2]));

  // R4
  alt_a0_chk: assert property (@(posedge clk) disable iff (rst)
    in_rd[0] && !in_empty[1] |=> !in_rd[0]);

  // R4
  alt_b0_chk: assert property (@(posedge clk) disable iff (rst)
    in_rd[1] && !in_empty[0] |=> !in_rd[1]);

  // R4
  alt_a1_chk: assert property (@(posedge clk) disable iff (rst)
    in_rd[2] && !in_empty[3] |=> !in_rd[2]);

  // R4
  alt_b1_chk: assert property (@(posedge clk) disable iff (rst)
    in_rd[3] && !in_empty[2] |=> !in_rd[3]);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind fm_merge4 fm_merge4_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_empty  (in_empty),
  .in_rd     (in_rd),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/fm_merge4_test.sv
module fm_merge4_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int NVEC = 5;

  // {cnt3, cnt2, cnt1, cnt0, length, sequence (first word in top byte)}
  localparam logic [83:0] VEC [NVEC] = '{
    {4'd2, 4'd2, 4'd2, 4'd2, 4'd8, 64'h0020103001211131}, // R7 R5
    {4'd0, 4'd0, 4'd0, 4'd3, 4'd3, 64'h0001020000000000}, // R6 R9
    {4'd0, 4'd0, 4'd1, 4'd3, 4'd4, 64'h0010010200000000}, // R4 R5
    {4'd2, 4'd0, 4'd2, 4'd0, 4'd4, 64'h1030113100000000}, // R5 root
    {4'd1, 4'd0, 4'd0, 4'd3, 4'd4, 64'h0030010200000000}  // R6 partner drains
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] in_empty;
  logic [4*DATA_W-1:0] in_data;
  logic [3:0] in_rd;
  logic out_valid;
  logic [DATA_W-1:0] out_data;
  logic out_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rd_bad = 0;
  int pair_bad = 0;

  logic [DATA_W-1:0] fifo_mem [4][16];
  int fifo_len [4];
  int fifo_head [4];
  logic [DATA_W-1:0] cap [16];
  int cap_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_merge4 #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .in_empty(in_empty), .in_data(in_data),
    .in_rd(in_rd), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      in_empty[i] = (fifo_head[i] >= fifo_len[i]);
      in_data[i*DATA_W +: DATA_W] = fifo_mem[i][fifo_head[i] & 15];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 4; i++) fifo_head[i] <= 0;
      cap_n <= 0;
    end else begin
      for (int i = 0; i < 4; i++) if (in_rd[i]) fifo_head[i] <= fifo_head[i] + 1;
      if ((in_rd & in_empty) != 4'b0) rd_bad <= rd_bad + 1;
      if ((in_rd[0] && in_rd[1]) || (in_rd[2] && in_rd[3])) pair_bad <= pair_bad + 1;
      if (out_valid && out_ready && cap_n < 16) begin
        cap[cap_n] <= out_data;
        cap_n <= cap_n + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_and_reset(input logic [15:0] cnts, input logic rdy);
    rst = 1'b1;
    out_ready = rdy;
    for (int i = 0; i < 4; i++) begin
      fifo_len[i] = int'(cnts[i*4 +: 4]);
      for (int k = 0; k < 16; k++) fifo_mem[i][k] = {i[3:0], k[3:0]};
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      fifo_len[i] = 0;
      for (int k = 0; k < 16; k++) fifo_mem[i][k] = '0;
    end
    // R1: reset state with every FIFO empty
    load_and_reset(16'h0000, 1'b1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_rd == 4'b0, "R1 in_rd", 64'(in_rd), 64'd0);

    // table of vectors, each run with free flow and toggling ready
    for (int v = 0; v < NVEC; v++) begin
      for (int m = 0; m < 2; m++) begin
        logic [63:0] got;
        int len;
        len = int'(VEC[v][67:64]);
        load_and_reset(VEC[v][83:68], (m == 0));
        for (int t = 0; t < 200 && cap_n < len; t++) begin
          @(negedge clk);
          if (m == 1) out_ready = ~out_ready;
        end
        out_ready = 1'b1;
        repeat (6) @(negedge clk);
        got = '0;
        for (int k = 0; k < 8; k++) if (k < cap_n) got[63-8*k -: 8] = cap[k];
        check(cap_n == len && got == VEC[v][63:0],
              (m == 0) ? "R5/R7 order" : "R8/R9 order under stalls",
              got ^ (64'(cap_n) << 60) ^ (64'(cap_n) << 60), VEC[v][63:0]);
      end
    end

    // R8: stall holds the word, then it drains in order
    load_and_reset(16'h0002, 1'b0);
    repeat (4) @(negedge clk);
    check(out_valid && out_data == 8'h00, "R8 held word", 64'(out_data), 64'h00);
    @(negedge clk);
    check(out_valid && out_data == 8'h00, "R8 still held", 64'(out_data), 64'h00);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(cap_n == 2 && cap[0] == 8'h00 && cap[1] == 8'h01, "R9 after stall",
          {cap[0], cap[1]}, 64'h0001);

    // R6: lone input streams one word per cycle
    load_and_reset(16'h0400, 1'b1);
    for (int t = 0; t < 10 && !out_valid; t++) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(out_valid && out_data == {4'd2, k[3:0]}, "R6 back-to-back",
            64'(out_data), 64'({4'd2, k[3:0]}));
      @(negedge clk);
    end
    check(!out_valid, "R6 drained", 64'(out_valid), 64'd0);

    // R2 and R3 over the whole run
    check(rd_bad == 0, "R2 read of empty input", 64'(rd_bad), 64'd0);
    check(pair_bad == 0, "R3 two reads in one pair", 64'(pair_bad), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule